// File: doc/BRIEF.md
# Temperature Conversion Sequencer

This block decides when the temperature converter runs and how each finished measurement reaches the temperature register. After reset it converts back to back at the coarsest resolution. A sleep control stops the conversions, but only after the one in progress has finished and been posted. While asleep, a single-conversion request runs exactly one measurement.

A two-bit resolution code picks one of four output formats, each with its own conversion time. The result is masked to the chosen resolution. Bit 0 of the temperature register is either a read-driven change marker or, at full resolution, the data LSB.

The converter itself is modelled by a timer. A prescaler turns the clock into ticks, and a conversion lasts a set number of ticks for each resolution. When the timer expires, the raw input word is sampled as the result. Host reads arrive as single-cycle strobes from the register interface that sits around this block.

Top module: `tsq_conv_seq`

## Requirements
- R1: While reset is asserted, the temperature register reads 0000h, the data-ready flag is 0 and the done strobe is 0. After release the block converts continuously at the 13-bit setting.
- R2: A conversion at resolution code c lasts T_c × TICK_DIV clock cycles, where T_c is CONV_T13, CONV_T14, CONV_T15 or CONV_T16. In continuous mode the next conversion starts at the edge where the previous one finishes.
- R3: Resolution code 00 selects 13 bits, 01 selects 14 bits, 10 selects 15 bits and 11 selects 16 bits. The code is sampled when a conversion starts, so a change applies from the following conversion.
- R4: At 13, 14 and 15 bits, register bits below the resolution (bits 2..0, 1..0 and 0 respectively) are held at 0 in the data, and bit 0 is replaced by the change marker. At 16 bits all sixteen raw bits appear unchanged.
- R5: Below 16 bits, bit 0 of the temperature register inverts on a temperature read only if a conversion has finished since the previous temperature read. Otherwise it keeps its value.
- R6: The control-side change bit follows the same rule as R5, using control reads.
- R7: The data-ready flag goes to 1 at every conversion completion. A temperature read clears it, and the start of a single conversion clears it.
- R8: The done strobe is high for exactly one cycle, in the cycle where the new result first appears on the temperature register.
- R9: When sleep is requested, the conversion in progress runs to completion and posts its result. After that no further conversion runs, and the temperature register holds the last result.
- R10: While asleep and idle, a single-conversion request runs one conversion. During it the temperature register reads 8000h. At its end the result is posted and the block returns to idle.
- R11: A single-conversion request while in continuous mode has no effect.
- R12: Clearing sleep while idle resumes continuous conversion on the next cycle.
- R13: Register reads do not stop, restart or lengthen a conversion in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Level: 1 requests shutdown, 0 requests continuous conversion |
| shot_req | input | 1 | Single-cycle request for one conversion while asleep |
| res_sel | input | 2 | Resolution code (00 = 13-bit … 11 = 16-bit) |
| temp_rd | input | 1 | Strobe: temperature register read |
| ctl_rd | input | 1 | Strobe: control register read |
| raw_val | input | DATA_W | Raw converter word, sampled at completion |
| temp_reg | output | DATA_W | Temperature register contents |
| data_ready | output | 1 | Data-ready flag |
| ctl_toggle | output | 1 | Change bit shown in the control register |
| conv_done | output | 1 | One-cycle pulse at each result update |

## Verification
The bench builds the block with TICK_DIV = 2 and conversion lengths of 3, 4, 5 and 6 ticks. This gives periods of 6, 8, 10 and 12 cycles, so every resolution, every code change at a conversion boundary, and a sleep entered mid-conversion occur within a few hundred cycles. The short periods also let a double read, a single-conversion placeholder check and idle hold windows fit between two completions. Each interval can therefore be compared against the exact cycle count.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_RUN  = 2'd1,
      SEQ_SHOT = 2'd2
   } seq_state_e;

   localparam logic [1:0] RES_13 = 2'd0;
   localparam logic [1:0] RES_16 = 2'd3;

   localparam int FLIP_N = 2;

endpackage

// File: rtl/tsq_timer.sv
module tsq_timer #(
   parameter int TICK_DIV = 1000,
   parameter int CNT_W    = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic             fin
);

   logic             tick;
   logic [CNT_W-1:0] tcnt;

   if (TICK_DIV > 1) begin : g_pre
      localparam int PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] pre;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        pre <= '0;
         else if (restart)  pre <= '0;
         else if (run)      pre <= (pre == PRE_LAST) ? '0 : pre + 1'b1;
      end

      assign tick = (pre == PRE_LAST);
   end else begin : g_nopre
      assign tick = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            tcnt <= '0;
      else if (restart)      tcnt <= '0;
      else if (run && tick)  tcnt <= tcnt + 1'b1;
   end

   assign fin = run && tick && (tcnt == limit - 1'b1);

endmodule

// File: rtl/tsq_flip.sv
module tsq_flip (
   input  logic clk,
   input  logic rst_n,
   input  logic mark,
   input  logic rd,
   output logic bit_o
);

   logic fresh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fresh <= 1'b0;
         bit_o <= 1'b0;
      end else begin
         if (rd && fresh) bit_o <= ~bit_o;
         fresh <= mark | (fresh & ~rd);
      end
   end

endmodule

// File: rtl/tsq_result.sv
module tsq_result
   import tsq_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [1:0]        res_code,
   input  logic [DATA_W-1:0] raw,
   input  logic              shot,
   input  logic              flip_bit,
   output logic [DATA_W-1:0] temp_o
);

   localparam logic [DATA_W-1:0] PLACEHOLDER = {1'b1, {(DATA_W-1){1'b0}}};

   logic [DATA_W-1:0] keep_q;
   logic [1:0]        res_q;
   logic [1:0]        cut;
   logic [DATA_W-1:0] mask;

   assign cut  = 2'd3 - res_code;
   assign mask = {DATA_W{1'b1}} << cut;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         keep_q <= '0;
         res_q  <= RES_13;
      end else if (load) begin
         keep_q <= raw & mask;
         res_q  <= res_code;
      end
   end

   assign temp_o = shot ? PLACEHOLDER
                        : {keep_q[DATA_W-1:1], (res_q == RES_16) ? keep_q[0] : flip_bit};

endmodule

// File: rtl/tsq_conv_seq.sv
module tsq_conv_seq
   import tsq_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int TICK_DIV  = 1000,
   parameter int CONV_T13  = 43,
   parameter int CONV_T14  = 87,
   parameter int CONV_T15  = 175,
   parameter int CONV_T16  = 350
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep_req,
   input  logic              shot_req,
   input  logic [1:0]        res_sel,
   input  logic              temp_rd,
   input  logic              ctl_rd,
   input  logic [DATA_W-1:0] raw_val,
   output logic [DATA_W-1:0] temp_reg,
   output logic              data_ready,
   output logic              ctl_toggle,
   output logic              conv_done
);

   localparam int TMAX   = (CONV_T16 > CONV_T15) ? CONV_T16 : CONV_T15;
   localparam int TCNT_W = $clog2(TMAX + 1);

   if (DATA_W < 4) begin : g_bad_width
      $error("tsq_conv_seq: DATA_W must be at least 4");
   end
   if (TICK_DIV < 1) begin : g_bad_div
      $error("tsq_conv_seq: TICK_DIV must be at least 1");
   end
   if (CONV_T13 < 1 || CONV_T14 < 1 || CONV_T15 < 1 || CONV_T16 < 1) begin : g_bad_len
      $error("tsq_conv_seq: conversion lengths must be at least one tick");
   end
   if (CONV_T13 * TICK_DIV < 2) begin : g_bad_short
      $error("tsq_conv_seq: shortest conversion must span two cycles");
   end

   seq_state_e        st_q, st_d;
   logic [1:0]        res_q;
   logic              fin, restart, shot_go;
   logic [TCNT_W-1:0] limit;
   logic [FLIP_N-1:0] rd_vec, flip_bits;

   always_comb begin
      case (res_q)
         2'd0:    limit = TCNT_W'(CONV_T13);
         2'd1:    limit = TCNT_W'(CONV_T14);
         2'd2:    limit = TCNT_W'(CONV_T15);
         default: limit = TCNT_W'(CONV_T16);
      endcase
   end

   always_comb begin
      st_d    = st_q;
      shot_go = 1'b0;
      case (st_q)
         SEQ_IDLE: begin
            if (!sleep_req) begin
               st_d = SEQ_RUN;
            end else if (shot_req) begin
               st_d    = SEQ_SHOT;
               shot_go = 1'b1;
            end
         end
         SEQ_RUN:  if (fin && sleep_req) st_d = SEQ_IDLE;
         SEQ_SHOT: if (fin)              st_d = SEQ_IDLE;
         default:  st_d = SEQ_IDLE;
      endcase
   end

   assign restart = fin || (st_q == SEQ_IDLE && st_d != SEQ_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= SEQ_RUN;
         res_q      <= RES_13;
         data_ready <= 1'b0;
         conv_done  <= 1'b0;
      end else begin
         st_q      <= st_d;
         conv_done <= fin;
         if (restart && st_d != SEQ_IDLE) res_q <= res_sel;
         if (fin)                         data_ready <= 1'b1;
         else if (shot_go || temp_rd)     data_ready <= 1'b0;
      end
   end

   tsq_timer #(
      .TICK_DIV (TICK_DIV),
      .CNT_W    (TCNT_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .run     (st_q != SEQ_IDLE),
      .limit   (limit),
      .fin     (fin)
   );

   assign rd_vec = {ctl_rd, temp_rd};

   for (genvar gi = 0; gi < FLIP_N; gi++) begin : g_flip
      tsq_flip u_flip (
         .clk   (clk),
         .rst_n (rst_n),
         .mark  (fin),
         .rd    (rd_vec[gi]),
         .bit_o (flip_bits[gi])
      );
   end

   assign ctl_toggle = flip_bits[1];

   tsq_result #(
      .DATA_W (DATA_W)
   ) u_result (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (fin),
      .res_code (res_q),
      .raw      (raw_val),
      .shot     (st_q == SEQ_SHOT),
      .flip_bit (flip_bits[0]),
      .temp_o   (temp_reg)
   );

endmodule

// File: rtl/tsq_conv_seq_chk.sv
module tsq_conv_seq_chk
   import tsq_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        st,
   input logic [DATA_W-2:0] temp_hi,
   input logic              data_ready,
   input logic              conv_done,
   input logic              ctl_rd,
   input logic              ctl_toggle
);

   AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SEQ_IDLE) |=> !conv_done);  // R9

   AST_IDLE_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SEQ_IDLE && $past(st) == SEQ_IDLE) |-> $stable(temp_hi));  // R9

   AST_SHOT_FLAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SEQ_SHOT) |-> !data_ready);  // R7

   AST_DONE_FLAG_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |-> data_ready);  // R7

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |=> !conv_done);  // R8

   AST_RUN_NO_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SEQ_RUN) |=> (st != SEQ_SHOT));  // R11

   AST_CTL_FLIP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rd && $past(ctl_rd) && !conv_done) |=> $stable(ctl_toggle));  // R6

endmodule

bind tsq_conv_seq tsq_conv_seq_chk #(
   .DATA_W (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .st         (st_q),
   .temp_hi    (temp_reg[DATA_W-1:1]),
   .data_ready (data_ready),
   .conv_done  (conv_done),
   .ctl_rd     (ctl_rd),
   .ctl_toggle (ctl_toggle)
);

// File: tb/tb_tsq_conv_seq.sv
module tb_tsq_conv_seq;

   localparam int CLK_PERIOD = 10;
   localparam int DIV = 2;
   localparam int T13 = 3, T14 = 4, T15 = 5, T16 = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sleep_req = 1'b0, shot_req = 1'b0, temp_rd = 1'b0, ctl_rd = 1'b0;
   logic [1:0]  res_sel = 2'd0;
   logic [15:0] raw_val = 16'h5787;
   logic [15:0] temp_reg;
   logic        data_ready, ctl_toggle, conv_done;

   always #(CLK_PERIOD/2) clk = ~clk;

   tsq_conv_seq #(
      .DATA_W(16), .TICK_DIV(DIV),
      .CONV_T13(T13), .CONV_T14(T14), .CONV_T15(T15), .CONV_T16(T16)
   ) dut (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .shot_req(shot_req),
      .res_sel(res_sel), .temp_rd(temp_rd), .ctl_rd(ctl_rd), .raw_val(raw_val),
      .temp_reg(temp_reg), .data_ready(data_ready), .ctl_toggle(ctl_toggle),
      .conv_done(conv_done)
   );

   typedef struct packed {
      logic [15:0] raw;
      logic [1:0]  res;
      logic [15:0] gap;
   } exp_t;

   exp_t sb_q[$];
   int   pending = 0;
   int   checks = 0, fails = 0;
   int   gap_cnt = 0, last_gap = 0;
   bit   prev_done = 0;
   bit   ended = 0;

   function automatic logic [15:0] model(input logic [15:0] raw, input logic [1:0] res);
      case (res)
         2'd0:    return raw & 16'hFFF8;
         2'd1:    return raw & 16'hFFFC;
         2'd2:    return raw & 16'hFFFE;
         default: return raw;
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   task automatic push(input logic [15:0] raw, input logic [1:0] res, input int gap);
      exp_t e;
      e.raw = raw; e.res = res; e.gap = 16'(gap);
      sb_q.push_back(e);
      pending++;
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   // monitor: pops one expectation per completion
   always @(negedge clk) begin
      exp_t e;
      logic [15:0] ev;
      if (!rst_n) begin
         gap_cnt = 0;
         prev_done = 0;
      end else begin
         gap_cnt++;
         if (prev_done) chk(!conv_done, "R8", "done pulse width", 32'(conv_done), 0);
         if (conv_done) begin
            if (sb_q.size() == 0) begin
               chk(0, "R9", "unexpected conversion", 32'(temp_reg), 0);
            end else begin
               e = sb_q.pop_front();
               pending--;
               ev = model(e.raw, e.res);
               if (e.res == 2'd3)
                  chk(temp_reg == ev, "R4", "full resolution result", 32'(temp_reg), 32'(ev));
               else
                  chk(temp_reg[15:1] == ev[15:1], "R3", "masked result",
                      32'(temp_reg[15:1]), 32'(ev[15:1]));
               if (e.gap != 0)
                  chk(gap_cnt == int'(e.gap), "R2", "conversion period", 32'(gap_cnt), 32'(e.gap));
               chk(data_ready, "R7", "flag after completion", 32'(data_ready), 1);
            end
            last_gap = gap_cnt;
            gap_cnt = 0;
         end
         prev_done = conv_done;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      chk(0, "R2", "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      logic b0, c0;
      logic [15:0] held;
      repeat (3) @(negedge clk);
      chk(temp_reg == 16'h0000, "R1", "reset register", 32'(temp_reg), 0);
      chk(!data_ready, "R1", "reset flag", 32'(data_ready), 0);
      chk(!conv_done, "R1", "reset strobe", 32'(conv_done), 0);
      rst_n = 1'b1;

      // continuous 13-bit from reset
      push(16'h5787, 2'd0, 0);
      push(16'h5787, 2'd0, T13*DIV);
      wait (pending == 0);

      // resolution changes take effect one conversion later
      @(negedge clk); res_sel = 2'd1; raw_val = 16'h4B03;
      push(16'h4B03, 2'd0, T13*DIV); push(16'h4B03, 2'd1, T14*DIV);
      wait (pending == 0);
      @(negedge clk); res_sel = 2'd2; raw_val = 16'h0C83;
      push(16'h0C83, 2'd1, T14*DIV); push(16'h0C83, 2'd2, T15*DIV);
      wait (pending == 0);
      @(negedge clk); res_sel = 2'd3; raw_val = 16'hEC01;
      push(16'hEC01, 2'd2, T15*DIV); push(16'hEC01, 2'd3, T16*DIV);
      wait (pending == 0);
      @(negedge clk); raw_val = 16'hFFFF;
      push(16'hFFFF, 2'd3, T16*DIV);
      wait (pending == 0);

      // back to 13-bit, then reads and an ignored single request
      @(negedge clk); res_sel = 2'd0; raw_val = 16'h1235;
      push(16'h1235, 2'd3, T16*DIV); push(16'h1235, 2'd0, T13*DIV);
      wait (pending == 0);
      @(negedge clk);
      push(16'h1235, 2'd0, T13*DIV);
      b0 = temp_reg[0]; c0 = ctl_toggle;
      temp_rd = 1'b1; ctl_rd = 1'b1; shot_req = 1'b1;
      @(negedge clk);
      temp_rd = 1'b0; ctl_rd = 1'b0; shot_req = 1'b0;
      chk(temp_reg[0] == ~b0, "R5", "marker after fresh read", 32'(temp_reg[0]), 32'(~b0));
      chk(ctl_toggle == ~c0, "R6", "control bit after fresh read", 32'(ctl_toggle), 32'(~c0));
      chk(!data_ready, "R7", "flag cleared by read", 32'(data_ready), 0);
      chk(temp_reg != 16'h8000, "R11", "no placeholder in continuous", 32'(temp_reg), 32'h1230);
      @(negedge clk);
      temp_rd = 1'b1; ctl_rd = 1'b1;
      @(negedge clk);
      temp_rd = 1'b0; ctl_rd = 1'b0;
      chk(temp_reg[0] == ~b0, "R5", "marker after stale read", 32'(temp_reg[0]), 32'(~b0));
      chk(ctl_toggle == ~c0, "R6", "control bit after stale read", 32'(ctl_toggle), 32'(~c0));
      wait (pending == 0);
      chk(last_gap == T13*DIV, "R13", "period with reads", 32'(last_gap), 32'(T13*DIV));

      // sleep mid-conversion: one more completion, then hold
      @(negedge clk); sleep_req = 1'b1; raw_val = 16'h0C8F;
      push(16'h0C8F, 2'd0, T13*DIV);
      wait (pending == 0);
      held = temp_reg;
      repeat (20) @(negedge clk);
      chk(temp_reg == held, "R9", "register held in sleep", 32'(temp_reg), 32'(held));

      // single conversion from sleep
      @(negedge clk); raw_val = 16'h2803; shot_req = 1'b1;
      push(16'h2803, 2'd0, 0);
      @(negedge clk); shot_req = 1'b0;
      chk(temp_reg == 16'h8000, "R10", "placeholder during single", 32'(temp_reg), 32'h8000);
      chk(!data_ready, "R7", "flag low during single", 32'(data_ready), 0);
      wait (pending == 0);
      repeat (20) @(negedge clk);
      chk(temp_reg[15:1] == 15'h1400, "R10", "result kept after single",
          32'(temp_reg[15:1]), 32'h1400);

      // wake up
      @(negedge clk); sleep_req = 1'b0; raw_val = 16'h4B07;
      push(16'h4B07, 2'd0, 0); push(16'h4B07, 2'd0, T13*DIV);
      wait (pending == 0);
      chk(temp_reg[15:1] == 15'h2580, "R12", "conversions resumed",
          32'(temp_reg[15:1]), 32'h2580);

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule